// File: doc/BRIEF.md
# BCD Watchdog Interval Timer

This block is a down-counting watchdog and interval timer with a resolution of one hundredth of a second. A host programs a four-digit BCD period from 00.01 s to 99.99 s into two 8-bit period registers. A 100 Hz tick enable drives the count. When the count runs out before software has touched the timer, the block raises a sticky interrupt flag. That flag can restart a processor whose software has stopped servicing the timer, or it can act as a periodic interval event.

Software keeps the timer alive by writing or reading either period register. A write stores the new value, restarts the count and drops any pending flag. A read restarts the count and leaves both the stored period and the flag alone. A stored period of 00.00 turns the timer off. The host clears the flag through a dedicated clear strobe.

Top module: `wdt_bcd_timer`

## Requirements
- R1: After reset the interrupt flag is low, both period registers hold 0x00, and read data is 0x00 at either address.
- R2: Register address 0 holds hundredths in bits 3:0 and tenths in bits 7:4. Address 1 holds units of seconds in bits 3:0 and tens of seconds in bits 7:4. `rdata_o` shows the register selected by `addr_i` in the same cycle.
- R3: With a stored period of N hundredths, the flag rises on exactly the N-th counted tick after the last restart. A counted tick is a cycle with `tick_i` and `en_i` high and no register access.
- R4: On expiry the flag goes high and stays high, and the count restarts from the stored period. Expiries therefore repeat every N counted ticks.
- R5: A write to either register stores the data, restarts the count from the new period and clears the flag in that cycle.
- R6: A read of either register restarts the count. It does not change the stored period or the flag.
- R7: While the stored period is 00.00, the flag never rises.
- R8: While `en_i` is low, ticks are ignored and the count holds. Counting resumes from the held value.
- R9: `irq_clr_i` clears the flag. If an expiry happens in the same cycle, the flag is set.
- R10: A register access in a tick cycle restarts the count, and that tick is not counted.
- R11: The count borrows across all four BCD digits. Period 01.00 takes 100 ticks and period 99.99 takes 9999 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz count enable, one cycle wide |
| en_i | input | 1 | Timer enable |
| wr_i | input | 1 | Period register write strobe |
| rd_i | input | 1 | Period register read strobe |
| addr_i | input | 1 | Register select (0 fractional, 1 seconds) |
| wdata_i | input | 8 | Write data, two BCD digits |
| rdata_o | output | 8 | Read data of the selected register |
| irq_clr_i | input | 1 | Interrupt flag clear |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with its default of four BCD digits, so the period is the full 00.01 to 99.99 s range. With a tick on every clock, the longest period of 9999 ticks and the digit borrows at 01.00 fit well within the run. Short random periods with random accesses, clears, enable gaps and tick gaps reach the same-cycle collisions between expiry, clear and restart.

// File: rtl/wdt_bcd_pkg.sv
package wdt_bcd_pkg;
  localparam int unsigned DIG_W = 4;
  localparam int unsigned REG_W = 8;
  localparam logic [DIG_W-1:0] DIG_MAX = 4'd9;
  typedef logic [DIG_W-1:0] bcd_t;
endpackage

// File: rtl/wdt_bcd_dec_digit.sv
module wdt_bcd_dec_digit
  import wdt_bcd_pkg::*;
(
  input  bcd_t d_i,
  input  logic borrow_i,
  output bcd_t q_o,
  output logic borrow_o
);
  logic at_zero;
  assign at_zero  = (d_i == '0);
  assign q_o      = !borrow_i ? d_i : (at_zero ? DIG_MAX : d_i - 1'b1);
  assign borrow_o = borrow_i & at_zero;
endmodule

// File: rtl/wdt_bcd_down_cnt.sv
module wdt_bcd_down_cnt
  import wdt_bcd_pkg::*;
#(
  parameter int unsigned NDIG = 4,
  localparam int unsigned W = NDIG * DIG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] count_o,
  output logic         one_o
);
  logic [W-1:0] count_q, count_dec;
  logic [NDIG:0] borrow;

  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    wdt_bcd_dec_digit u_dig (
      .d_i     (count_q[g*DIG_W +: DIG_W]),
      .borrow_i(borrow[g]),
      .q_o     (count_dec[g*DIG_W +: DIG_W]),
      .borrow_o(borrow[g+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (dec_i)  count_q <= count_dec;
  end

  assign count_o = count_q;
  assign one_o   = (count_q == W'(1));
endmodule

// File: rtl/wdt_bcd_period_regs.sv
module wdt_bcd_period_regs
  import wdt_bcd_pkg::*;
#(
  parameter int unsigned NDIG = 4,
  localparam int unsigned W = NDIG * DIG_W,
  localparam int unsigned NREG = W / REG_W,
  localparam int unsigned AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [W-1:0]     period_o,
  output logic [W-1:0]     reload_o
);
  logic [REG_W-1:0] reg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_i && (addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  reg_q[g] <= '0;
      else if (hit) reg_q[g] <= wdata_i;
    end

    assign period_o[g*REG_W +: REG_W] = reg_q[g];
    // value the period takes after this cycle's write
    assign reload_o[g*REG_W +: REG_W] = hit ? wdata_i : reg_q[g];
  end

  assign rdata_o = reg_q[addr_i];
endmodule

// File: rtl/wdt_bcd_timer.sv
module wdt_bcd_timer
  import wdt_bcd_pkg::*;
#(
  parameter int unsigned NDIG = 4,
  localparam int unsigned W = NDIG * DIG_W,
  localparam int unsigned NREG = W / REG_W,
  localparam int unsigned AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             irq_clr_i,
  output logic             irq_o
);
  logic [W-1:0] period_q, reload_val, count_q, load_val;
  logic access, step, expire, cnt_one, cnt_load, irq_q;

  wdt_bcd_period_regs #(.NDIG(NDIG)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .period_o(period_q),
    .reload_o(reload_val)
  );

  assign access   = wr_i | rd_i;
  assign step     = tick_i & en_i & ~access & (period_q != '0);
  assign expire   = step & cnt_one;
  assign cnt_load = access | expire;
  assign load_val = access ? reload_val : period_q;

  wdt_bcd_down_cnt #(.NDIG(NDIG)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cnt_load),
    .load_val_i(load_val),
    .dec_i     (step & ~cnt_one),
    .count_o   (count_q),
    .one_o     (cnt_one)
  );

  // write clears, expiry beats host clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (wr_i)      irq_q <= 1'b0;
    else if (expire)    irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/wdt_bcd_timer_chk.sv
module wdt_bcd_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         en_i,
  input logic         wr_i,
  input logic         rd_i,
  input logic         irq_clr_i,
  input logic         irq_o,
  input logic [W-1:0] period_i,
  input logic [W-1:0] count_i
);
  p_irq_needs_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tick_i && en_i));

  p_count_bounded_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= period_i);

  p_write_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !irq_o);

  p_read_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> ($stable(period_i) && $stable(irq_o)));

  p_zero_period_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0 && !wr_i) |=> !$rose(irq_o));

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_i && !rd_i) |=> $stable(count_i));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !tick_i) |=> !irq_o);
endmodule

bind wdt_bcd_timer wdt_bcd_timer_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .en_i     (en_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .irq_clr_i(irq_clr_i),
  .irq_o    (irq_o),
  .period_i (period_q),
  .count_i  (count_q)
);

// File: tb/wdt_bcd_timer_bench.sv
module wdt_bcd_timer_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tick_i = 0, en_i = 0, wr_i = 0, rd_i = 0, irq_clr_i = 0;
  logic [0:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic irq_o;

  int checks = 0, fails = 0;
  int m_reg [2];
  int m_cnt = 0;
  bit m_irq = 0;
  string tag = "R1";

  always #5 clk_i = ~clk_i;

  wdt_bcd_timer u_wdt_bcd_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i),
    .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_clr_i(irq_clr_i), .irq_o(irq_o)
  );

  function automatic int b2i(int b);
    return (b & 15) + 10 * ((b >> 4) & 15);
  endfunction

  function automatic int per_hund();
    return b2i(m_reg[0]) + 100 * b2i(m_reg[1]);
  endfunction

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, check read data, model the edge, check flag
  task automatic cyc(bit wr, bit rd, bit a, int wd, bit tk, bit en, bit clr);
    bit exp_now;
    wr_i = wr; rd_i = rd; addr_i = a; wdata_i = 8'(wd);
    tick_i = tk; en_i = en; irq_clr_i = clr;
    #1;
    check({tag, " rdata (R2)"}, int'(rdata_o), m_reg[a]);
    @(posedge clk_i);
    exp_now = 0;
    if (wr) begin
      m_reg[a] = wd & 8'hff;
      m_cnt = per_hund();
    end else if (rd) begin
      m_cnt = per_hund();
    end else if (tk && en && per_hund() != 0) begin
      if (m_cnt == 1) begin
        exp_now = 1;
        m_cnt = per_hund();
      end else m_cnt--;
    end
    if (clr) m_irq = 0;
    if (exp_now) m_irq = 1;
    if (wr) m_irq = 0;
    @(negedge clk_i);
    check({tag, " irq"}, int'(irq_o), int'(m_irq));
  endtask

  task automatic run(int n, bit en);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, en, 0);
  endtask

  function automatic int rbcd(int maxtens);
    return (($urandom % (maxtens + 1)) << 4) | ($urandom % 10);
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    m_reg[0] = 0; m_reg[1] = 0;
    repeat (3) @(negedge clk_i);
    check("R1 irq after reset", int'(irq_o), 0);
    check("R1 rdata addr0", int'(rdata_o), 0);
    addr_i = 1; #1;
    check("R1 rdata addr1", int'(rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    tag = "R7"; run(40, 1);
    check("R7 no flag at 00.00", int'(irq_o), 0);

    tag = "R2"; cyc(1, 0, 0, 'h05, 0, 1, 0); cyc(1, 0, 1, 'h00, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    check("R2 frac readback", int'(rdata_o), 'h05);

    tag = "R3"; run(4, 1);
    check("R3 no flag before 5th tick", int'(irq_o), 0);
    run(1, 1);
    check("R3 flag on 5th tick", int'(irq_o), 1);
    tag = "R4"; run(12, 1);
    check("R4 flag sticky", int'(irq_o), 1);

    tag = "R9"; cyc(0, 0, 0, 0, 0, 1, 1);
    check("R9 clear", int'(irq_o), 0);
    run(2, 1);
    cyc(0, 0, 0, 0, 1, 1, 1);
    check("R9 expiry beats clear", int'(irq_o), 1);

    tag = "R5"; cyc(1, 0, 0, 'h07, 0, 1, 0);
    check("R5 write clears", int'(irq_o), 0);

    tag = "R8"; run(3, 1); run(30, 0);
    check("R8 frozen", int'(irq_o), 0);
    run(3, 1);
    check("R8 resumes from held count", int'(irq_o), 0);
    run(1, 1);
    check("R8 expiry after resume", int'(irq_o), 1);

    tag = "R6"; run(4, 1);
    cyc(0, 1, 0, 0, 1, 1, 0);
    check("R6 read keeps flag", int'(irq_o), 1);
    check("R6 read keeps period", int'(rdata_o), 'h07);
    cyc(0, 0, 0, 0, 0, 1, 1);
    run(6, 1);
    check("R6 count restarted", int'(irq_o), 0);

    tag = "R10"; cyc(1, 0, 0, 'h03, 1, 1, 0); run(2, 1);
    check("R10 access tick not counted", int'(irq_o), 0);
    run(1, 1);
    check("R10 expiry on 3rd tick", int'(irq_o), 1);

    tag = "R11"; cyc(1, 0, 0, 'h00, 0, 1, 0); cyc(1, 0, 1, 'h01, 0, 1, 0);
    run(99, 1);
    check("R11 01.00 not yet", int'(irq_o), 0);
    run(1, 1);
    check("R11 01.00 at 100", int'(irq_o), 1);
    cyc(1, 0, 0, 'h99, 0, 1, 0); cyc(1, 0, 1, 'h99, 0, 1, 0);
    run(9998, 1);
    check("R11 99.99 not yet", int'(irq_o), 0);
    run(1, 1);
    check("R11 99.99 at 9999", int'(irq_o), 1);

    tag = "R3";
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 2)
        cyc(1, 0, 1'($urandom % 2), rbcd(($urandom % 4 == 0) ? 1 : 0), 0, 1, 0);
      else if (r < 4)
        cyc(0, 1, 1'($urandom % 2), 0, 1'($urandom % 2), 1, 0);
      else
        cyc(0, 0, 1'($urandom % 2), 0, ($urandom % 4) != 0,
            ($urandom % 10) != 0, ($urandom % 8) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule